// File: doc/BRIEF.md
# Bridge Write Admission Controller

This block sits at the target side of a two-interface bus bridge and decides, for every write that starts, whether the bridge takes the write into its internal storage or answers with a target retry. It keeps two independent credit pools. The first counts free entries in the queue that holds delayed writes. The second counts free data beats in the buffer that holds posted writes. Because the pools are separate, a pile-up of one kind of write does not stall the other kind.

A write that starts with no idle cycle after the previous write is a fast back-to-back follow-on. Such a write is admitted only when the fast back-to-back permission for its direction is set. For traffic moving upstream, the permission comes from the command-register enable. For traffic moving downstream, it comes from the bridge-control enable. Release pulses from the drain side return credits to the pools. All decisions are registered, and each one appears one clock after the start strobe.

Top module: `wpost_admit`

## Requirements
- R1: After reset, `acc_o`, `rty_o`, `alloc_dq_o` and `alloc_pw_o` are low. The delayed queue holds DQ_DEPTH free entries and the posted buffer holds PW_DEPTH free beats.
- R2: In the cycle after `req_vld_i` is high, exactly one of `acc_o` and `rty_o` is high. In the cycle after `req_vld_i` is low, both are low.
- R3: A delayed write (`req_dly_i`=1) is accepted when at least one queue entry is free. Acceptance takes one entry and raises `alloc_dq_o` together with `acc_o`. When no entry is free, the write is retried.
- R4: A posted write (`req_dly_i`=0) of n beats is accepted when 1 <= n <= the free beat count. Acceptance takes n beats and raises `alloc_pw_o` together with `acc_o`. A posted write of zero beats, or of more beats than are free, is retried.
- R5: The two pools are independent. A full delayed queue does not block a posted write that fits, and a full posted buffer does not block a delayed write.
- R6: A follow-on write (`req_b2b_i`=1) with `req_up_i`=1 checks `cmd_fbb_en_i`, and one with `req_up_i`=0 checks `bctl_fbb_en_i`. When the selected enable is clear, the write is retried whatever the free space. The enable of the other direction has no effect. Writes with `req_b2b_i`=0 ignore both enables.
- R7: A follow-on write whose selected enable is set follows the rules of R3 and R4. If the space is insufficient, it is retried.
- R8: A `dq_rel_i` pulse returns one queue entry. A `pw_rel_i` pulse returns `pw_rel_beats_i` beats. A release is counted for requests that start in later cycles, not for a request that starts in the same cycle. An allocation and a release in the same cycle are both applied.
- R9: A release that would push a pool above its depth is clipped to the depth. No pool ever goes below zero.
- R10: A retried write takes no credit from either pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld_i | input | 1 | Write start strobe, one cycle per write |
| req_up_i | input | 1 | 1 = upstream, 0 = downstream |
| req_dly_i | input | 1 | 1 = delayed write, 0 = posted write |
| req_b2b_i | input | 1 | Write follows the previous one with no idle cycle |
| req_beats_i | input | BEAT_W | Beat count of a posted write |
| cmd_fbb_en_i | input | 1 | Fast back-to-back enable for upstream writes |
| bctl_fbb_en_i | input | 1 | Fast back-to-back enable for downstream writes |
| dq_rel_i | input | 1 | Return one delayed-queue entry |
| pw_rel_i | input | 1 | Return posted-buffer beats |
| pw_rel_beats_i | input | BEAT_W | Beats returned with `pw_rel_i` |
| acc_o | output | 1 | Write accepted (registered) |
| rty_o | output | 1 | Target retry (registered) |
| alloc_dq_o | output | 1 | Delayed-queue entry allocated (registered) |
| alloc_pw_o | output | 1 | Posted-buffer beats allocated (registered) |

## Verification
The bench builds the block with DQ_DEPTH=2 and PW_DEPTH=8. With these values, both pools can be filled to the last credit within a few requests. This exercises the exact-fit and one-over boundaries, saturation of the release clip, and the same-cycle allocate-and-release case. The fast back-to-back scenarios use a partly filled posted buffer, so that an enabled follow-on write can be seen both fitting and being refused for space.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'b00,
    VERD_ACC  = 2'b01,
    VERD_RTY  = 2'b10
  } verdict_t;

  typedef struct packed {
    logic up;
    logic dly;
    logic b2b;
  } req_attr_t;
endpackage

// File: rtl/wpa_credit_pool.sv
module wpa_credit_pool #(
  parameter int DEPTH = 4,
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] take_i,
  input  logic [FW-1:0] give_i,
  output logic [FW-1:0] free_o
);
  localparam int XW = FW + 1;
  localparam logic [XW-1:0] DEPTH_X = XW'(DEPTH);

  logic [XW-1:0] free_x, take_x, give_x, room_x, give_eff, next_x;
  logic [FW-1:0] free_q;

  always_comb begin
    free_x   = {1'b0, free_q};
    take_x   = {1'b0, take_i};
    give_x   = {1'b0, give_i};
    room_x   = DEPTH_X - free_x + take_x;
    give_eff = (give_x > room_x) ? room_x : give_x;
    next_x   = free_x - take_x + give_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= FW'(DEPTH);
    else     free_q <= next_x[FW-1:0];
  end

  assign free_o = free_q;

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    take_i <= free_q);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    {1'b0, free_q} <= DEPTH_X);
endmodule

// File: rtl/wpa_fbb_gate.sv
module wpa_fbb_gate (
  input  wpa_pkg::req_attr_t attr_i,
  input  logic               up_en_i,
  input  logic               dn_en_i,
  output logic               block_o
);
  logic sel_en;
  always_comb begin
    sel_en  = attr_i.up ? up_en_i : dn_en_i;
    block_o = attr_i.b2b & ~sel_en;
  end
endmodule

// File: rtl/wpa_decide.sv
module wpa_decide #(
  parameter int FW_DQ  = 3,
  parameter int BEAT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld_i,
  input  wpa_pkg::req_attr_t attr_i,
  input  logic [BEAT_W-1:0]  beats_i,
  input  logic               fbb_block_i,
  input  logic [FW_DQ-1:0]   dq_free_i,
  input  logic [BEAT_W-1:0]  pw_free_i,
  output logic [FW_DQ-1:0]   dq_take_o,
  output logic [BEAT_W-1:0]  pw_take_o,
  output logic               acc_o,
  output logic               rty_o,
  output logic               alloc_dq_o,
  output logic               alloc_pw_o
);
  import wpa_pkg::*;

  logic     dq_fit, pw_fit, grant;
  verdict_t verd;
  logic     acc_q, rty_q, adq_q, apw_q;

  always_comb begin
    dq_fit = (dq_free_i != '0);
    pw_fit = (beats_i != '0) && (beats_i <= pw_free_i);
    grant  = vld_i & ~fbb_block_i & (attr_i.dly ? dq_fit : pw_fit);
    verd   = !vld_i ? VERD_NONE : (grant ? VERD_ACC : VERD_RTY);
    dq_take_o = (grant & attr_i.dly) ? FW_DQ'(1) : '0;
    pw_take_o = (grant & ~attr_i.dly) ? beats_i : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      rty_q <= 1'b0;
      adq_q <= 1'b0;
      apw_q <= 1'b0;
    end else begin
      acc_q <= (verd == VERD_ACC);
      rty_q <= (verd == VERD_RTY);
      adq_q <= (verd == VERD_ACC) & attr_i.dly;
      apw_q <= (verd == VERD_ACC) & ~attr_i.dly;
    end
  end

  assign acc_o      = acc_q;
  assign rty_o      = rty_q;
  assign alloc_dq_o = adq_q;
  assign alloc_pw_o = apw_q;

  assert_one_resp_R2: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (acc_o ^ rty_o));
  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> (!acc_o && !rty_o));
  assert_alloc_kind_R3: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> (alloc_dq_o ^ alloc_pw_o));
  assert_fbb_retry_R6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && fbb_block_i) |=> rty_o);
  assert_dq_full_R3: assert property (@(posedge clk) disable iff (rst)
    (vld_i && attr_i.dly && dq_free_i == '0) |=> rty_o);
  assert_zero_beats_R4: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !attr_i.dly && beats_i == '0) |=> rty_o);
endmodule

// File: rtl/wpost_admit.sv
module wpost_admit #(
  parameter int DQ_DEPTH = 4,
  parameter int PW_DEPTH = 16,
  parameter int BEAT_W   = $clog2(PW_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld_i,
  input  logic              req_up_i,
  input  logic              req_dly_i,
  input  logic              req_b2b_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic              cmd_fbb_en_i,
  input  logic              bctl_fbb_en_i,
  input  logic              dq_rel_i,
  input  logic              pw_rel_i,
  input  logic [BEAT_W-1:0] pw_rel_beats_i,
  output logic              acc_o,
  output logic              rty_o,
  output logic              alloc_dq_o,
  output logic              alloc_pw_o
);
  import wpa_pkg::*;

  localparam int FW_DQ = $clog2(DQ_DEPTH + 1);

  req_attr_t         attr;
  logic              fbb_block;
  logic [FW_DQ-1:0]  dq_free, dq_take, dq_give;
  logic [BEAT_W-1:0] pw_free, pw_take, pw_give;

  always_comb begin
    attr.up  = req_up_i;
    attr.dly = req_dly_i;
    attr.b2b = req_b2b_i;
    dq_give  = dq_rel_i ? FW_DQ'(1) : '0;
    pw_give  = pw_rel_i ? pw_rel_beats_i : '0;
  end

  wpa_fbb_gate u_fbb (
    .attr_i  (attr),
    .up_en_i (cmd_fbb_en_i),
    .dn_en_i (bctl_fbb_en_i),
    .block_o (fbb_block)
  );

  wpa_credit_pool #(.DEPTH(DQ_DEPTH), .FW(FW_DQ)) u_dq_pool (
    .clk    (clk),
    .rst    (rst),
    .take_i (dq_take),
    .give_i (dq_give),
    .free_o (dq_free)
  );

  wpa_credit_pool #(.DEPTH(PW_DEPTH), .FW(BEAT_W)) u_pw_pool (
    .clk    (clk),
    .rst    (rst),
    .take_i (pw_take),
    .give_i (pw_give),
    .free_o (pw_free)
  );

  wpa_decide #(.FW_DQ(FW_DQ), .BEAT_W(BEAT_W)) u_decide (
    .clk         (clk),
    .rst         (rst),
    .vld_i       (req_vld_i),
    .attr_i      (attr),
    .beats_i     (req_beats_i),
    .fbb_block_i (fbb_block),
    .dq_free_i   (dq_free),
    .pw_free_i   (pw_free),
    .dq_take_o   (dq_take),
    .pw_take_o   (pw_take),
    .acc_o       (acc_o),
    .rty_o       (rty_o),
    .alloc_dq_o  (alloc_dq_o),
    .alloc_pw_o  (alloc_pw_o)
  );

  assert_rst_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!acc_o && !rty_o && !alloc_dq_o && !alloc_pw_o));
  assert_retry_no_take_R10: assert property (@(posedge clk) disable iff (rst)
    (dq_take != '0 || pw_take != '0) |=> acc_o);
endmodule

// File: tb/wpost_admit_tb_top.sv
module wpost_admit_tb_top;
  localparam int DQ = 2;
  localparam int PW = 8;
  localparam int BW = $clog2(PW + 1);

  localparam logic [3:0] E_IDLE = 4'b0000;
  localparam logic [3:0] E_ADQ  = 4'b1010;
  localparam logic [3:0] E_APW  = 4'b1001;
  localparam logic [3:0] E_RTY  = 4'b0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 0, req_up = 0, req_dly = 0, req_b2b = 0;
  logic [BW-1:0] req_beats = '0, pw_rel_beats = '0;
  logic cmd_en = 0, bctl_en = 0, dq_rel = 0, pw_rel = 0;
  logic acc, rty, adq, apw;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wpost_admit #(.DQ_DEPTH(DQ), .PW_DEPTH(PW)) dut_i (
    .clk(clk), .rst(rst), .req_vld_i(req_vld), .req_up_i(req_up),
    .req_dly_i(req_dly), .req_b2b_i(req_b2b), .req_beats_i(req_beats),
    .cmd_fbb_en_i(cmd_en), .bctl_fbb_en_i(bctl_en), .dq_rel_i(dq_rel),
    .pw_rel_i(pw_rel), .pw_rel_beats_i(pw_rel_beats),
    .acc_o(acc), .rty_o(rty), .alloc_dq_o(adq), .alloc_pw_o(apw)
  );

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {acc, rty, adq, apw};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {acc,rty,adq,apw} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // One write start; optional same-cycle releases; checks the registered verdict.
  task automatic wr(input string tag, input logic up, input logic dly,
                    input logic b2b, input int beats, input logic [3:0] exp,
                    input logic rdq = 0, input int rpw = 0);
    @(negedge clk);
    req_vld = 1; req_up = up; req_dly = dly; req_b2b = b2b;
    req_beats = BW'(beats);
    dq_rel = rdq; pw_rel = (rpw != 0); pw_rel_beats = BW'(rpw);
    @(negedge clk);
    req_vld = 0; req_b2b = 0; dq_rel = 0; pw_rel = 0; pw_rel_beats = '0;
    chk(tag, exp);
  endtask

  task automatic rel(input int ndq, input int npw);
    for (int i = 0; i < ndq; i++) begin
      @(negedge clk); dq_rel = 1;
    end
    if (npw != 0) begin
      @(negedge clk); dq_rel = 0; pw_rel = 1; pw_rel_beats = BW'(npw);
    end
    @(negedge clk);
    dq_rel = 0; pw_rel = 0; pw_rel_beats = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 idle outputs in reset", E_IDLE);
    rst = 0;
    @(negedge clk);
    chk("R2 no strobe no response", E_IDLE);
  endtask

  task automatic t_pools();
    wr("R1 R3 delayed 1", 0, 1, 0, 0, E_ADQ);
    wr("R3 delayed 2", 1, 1, 0, 0, E_ADQ);
    wr("R3 queue full retry", 0, 1, 0, 0, E_RTY);
    wr("R1 R5 full posted fits with queue full", 0, 0, 0, PW, E_APW);
    wr("R4 posted over free retry", 1, 0, 0, 1, E_RTY);
    wr("R5 R10 delayed still retried", 0, 1, 0, 0, E_RTY);
    rel(1, 3);
    wr("R8 delayed after release", 0, 1, 0, 0, E_ADQ);
    wr("R8 posted exact fit after release", 0, 0, 0, 3, E_APW);
    wr("R4 posted one over", 0, 0, 0, 1, E_RTY);
    rel(2, PW);
  endtask

  task automatic t_size_edges();
    wr("R4 zero beats retry", 0, 0, 0, 0, E_RTY);
    wr("R4 above capacity retry", 1, 0, 0, PW + 1, E_RTY);
    wr("R10 full fit after retries", 0, 0, 0, PW, E_APW);
    rel(0, PW);
  endtask

  task automatic t_overrelease();
    rel(3, 5);
    wr("R9 delayed a", 0, 1, 0, 0, E_ADQ);
    wr("R9 delayed b", 0, 1, 0, 0, E_ADQ);
    wr("R9 queue clipped at depth", 0, 1, 0, 0, E_RTY);
    wr("R9 posted full", 0, 0, 0, PW, E_APW);
    wr("R9 buffer clipped at depth", 0, 0, 0, 1, E_RTY);
    rel(2, PW);
  endtask

  task automatic t_b2b();
    cmd_en = 0; bctl_en = 1;
    wr("R6 up follow-on, cmd clear", 1, 0, 1, 1, E_RTY);
    wr("R6 up delayed follow-on, cmd clear", 1, 1, 1, 0, E_RTY);
    wr("R7 down follow-on, bctl set", 0, 0, 1, 1, E_APW);
    cmd_en = 1; bctl_en = 0;
    wr("R7 up follow-on, cmd set", 1, 0, 1, 1, E_APW);
    wr("R6 down follow-on, bctl clear", 0, 0, 1, 1, E_RTY);
    cmd_en = 0; bctl_en = 0;
    wr("R6 plain write ignores enables", 0, 0, 0, 1, E_APW);
    cmd_en = 1; bctl_en = 1;
    wr("R7 follow-on lacks space", 0, 0, 1, 6, E_RTY);
    wr("R7 follow-on exact fit", 1, 0, 1, 5, E_APW);
    cmd_en = 0; bctl_en = 0;
    rel(0, PW);
  endtask

  task automatic t_same_cycle();
    wr("R3 delayed take one", 0, 1, 0, 0, E_ADQ);
    wr("R8 alloc with release same cycle", 0, 1, 0, 0, E_ADQ, 1, 0);
    wr("R8 both applied, one left", 0, 1, 0, 0, E_ADQ);
    wr("R8 queue now full", 0, 1, 0, 0, E_RTY);
    rel(2, 0);
    wr("R8 posted fill", 0, 0, 0, PW, E_APW);
    wr("R8 release not seen same cycle", 0, 0, 0, 4, E_RTY, 0, 4);
    wr("R8 R10 release seen next cycle", 0, 0, 0, 4, E_APW);
    wr("R10 buffer full again", 0, 0, 0, 1, E_RTY);
  endtask

  initial begin
    t_reset();
    t_pools();
    t_size_edges();
    t_overrelease();
    t_b2b();
    t_same_cycle();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule